// File: doc/BRIEF.md
# Memory-to-Stream DMA Source Channel

This block is the source half of a simple DMA engine. Software programs a word-aligned start address and then writes a byte count. The channel then fetches 32-bit words one at a time over a request/acknowledge memory port and presents them on a valid/ready stream. A single-entry buffer sits between the memory side and the stream side, and each fetch waits until that buffer is empty.

Every fetched word is added into a 32-bit running checksum. A control bit can byte-reverse each word before it leaves the block, and another control bit keeps the address fixed for FIFO-style targets. Bit 0 of the count register requests an end-of-packet mark on the final word. Two pause bits halt fetching. An optional timer raises an event when the stream holds off a pending transfer for too long. Completion, bus errors and timeouts are reported as one-cycle event pulses to a separate interrupt block.

Top module: `mem2stream_src`

## Requirements
- R1: After reset the channel is idle, meaning status reads 0, `st_valid` is low and the checksum is 0. The control register (index 3) reads 0x003FF800, which is a timeout count of 0xFFE in bits [21:10]. The timer register (index 4) reads 0x0000FFF0, which is a prescale of 0xFFF in bits [15:4] with the enable bit [22] clear.
- R2: The address is split across two registers. Index 0 holds byte-address bits [31:2]; a write ignores bits [1:0] and those bits read back as 0. Index 1 holds the upper HI_W address bits. `mem_addr` is the concatenation {upper, lower}, and an advancing address carries from the lower register into the upper one.
- R3: A write to the count register (index 2) loads bytes [28:2] and captures bit 0 as the end-of-packet flag. Reading index 2 returns the remaining byte count ORed with that flag. A nonzero count sets busy, which is bit 0 of the status register (index 6).
- R4: Writing a count of zero never touches memory. In the cycle after the write, busy is 0 and `ev_done` and `ev_mem_done` pulse.
- R5: Each word accepted from memory without error is added, modulo 2^32, into the checksum register (index 5) before any byte swap. Software may overwrite the checksum.
- R6: When control bit 23 is set, each word leaves the block byte-reversed. When the bit is clear, the word passes through unchanged.
- R7: When control bit 22 is clear, the address advances by 4 bytes per word. When it is set, the address stays fixed. In both cases the remaining count drops by 4 bytes per word.
- R8: While control bit 0 or bit 1 is set, no memory request is issued and the address and count hold. Clearing both bits resumes the transfer.
- R9: `st_last` is high only on the final word of a transfer, and only when the captured end-of-packet flag is set.
- R10: In the cycle after the final word is accepted by the stream, busy is 0 and `ev_done` and `ev_mem_done` each pulse exactly once.
- R11: An acknowledge that carries `mem_err` pulses `ev_bus_err` in the next cycle. That word is still emitted and counted, but it is left out of the checksum.
- R12: When timer bit 22 is set, the timer runs on every cycle in which the channel is busy and `st_ready` is low. After TVAL x (PRE+1) such consecutive cycles, `ev_timeout` pulses once. Any cycle without the stall condition rearms the timer.
- R13: A count write while the channel is busy is accepted at once. It discards the buffered word and restarts the transfer from the current address.
- R14: A word offered on the stream keeps `st_valid` high and `st_data` steady until `st_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory word request |
| mem_addr | output | HI_W+32 | Memory byte address |
| mem_ack | input | 1 | Memory accepts request; data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Error response with acknowledge |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | End-of-packet mark |
| st_ready | input | 1 | Stream sink ready |
| ev_done | output | 1 | Transfer complete pulse |
| ev_mem_done | output | 1 | Memory-side complete pulse |
| ev_bus_err | output | 1 | Read error pulse |
| ev_timeout | output | 1 | Stream backpressure timeout pulse |

## Verification
Each result has a fixed arrival time, and the bench samples each one in its own due cycle.
- Memory data is read on the acknowledge edge and appears on the stream in the cycle after that edge. The bench collects stream words a quarter period before each rising edge, which is when the handshake becomes final.
- Completion, bus-error and zero-count events arrive one cycle after their cause. They are counted at every sample, so a missing pulse or an extra pulse is detected.
- The timeout pulse must land at exactly sample TVAL x (PRE+1) after the count write. The bench checks that index from the sample number recorded when the pulse appears.

// File: rtl/m2s_pkg.sv
package m2s_pkg;
   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] RA_ADDR_LO = 3'd0;
   localparam logic [REG_AW-1:0] RA_ADDR_HI = 3'd1;
   localparam logic [REG_AW-1:0] RA_SIZE    = 3'd2;
   localparam logic [REG_AW-1:0] RA_CTRL    = 3'd3;
   localparam logic [REG_AW-1:0] RA_TMR     = 3'd4;
   localparam logic [REG_AW-1:0] RA_SUM     = 3'd5;
   localparam logic [REG_AW-1:0] RA_STAT    = 3'd6;

   localparam int CTL_HOLD_A   = 0;
   localparam int CTL_HOLD_B   = 1;
   localparam int CTL_TVAL_LSB = 10;
   localparam int CTL_FIXED    = 22;
   localparam int CTL_SWAP     = 23;
   localparam int TMR_PRE_LSB  = 4;
   localparam int TMR_EN       = 22;

   localparam int TVAL_W = 12;
   localparam int TPRE_W = 12;
   localparam logic [TVAL_W-1:0] TVAL_RST = 12'hFFE;
   localparam logic [TPRE_W-1:0] TPRE_RST = 12'hFFF;

   typedef struct packed {
      logic              hold;
      logic              fixed;
      logic              swap;
      logic [TVAL_W-1:0] tval;
   } ctl_t;

   function automatic logic [31:0] rev_bytes(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
endpackage

// File: rtl/m2s_regs.sv
module m2s_regs
   import m2s_pkg::*;
#(
   parameter int HI_W  = 17,
   parameter int CNT_W = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   output ctl_t              ctl,
   output logic              tmr_en,
   output logic [TPRE_W-1:0] tpre,
   output logic              ld_lo,
   output logic              ld_hi,
   output logic              ld_size,
   output logic              ld_sum,
   input  logic [31:0]       addr_lo_q,
   input  logic [HI_W-1:0]   addr_hi_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              last_q,
   input  logic [31:0]       sum_q,
   input  logic              busy_q,
   output logic [31:0]       rdata
);
   logic              hold_a, hold_b, fixed_q, swap_q;
   logic [TVAL_W-1:0] tval_q;
   logic              unused_bits;

   assign unused_bits = ^{wdata[31:24], wdata[3:2]};

   assign ld_lo   = we && (addr == RA_ADDR_LO);
   assign ld_hi   = we && (addr == RA_ADDR_HI);
   assign ld_size = we && (addr == RA_SIZE);
   assign ld_sum  = we && (addr == RA_SUM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_a  <= 1'b0;
         hold_b  <= 1'b0;
         fixed_q <= 1'b0;
         swap_q  <= 1'b0;
         tval_q  <= TVAL_RST;
         tmr_en  <= 1'b0;
         tpre    <= TPRE_RST;
      end else if (we && addr == RA_CTRL) begin
         hold_a  <= wdata[CTL_HOLD_A];
         hold_b  <= wdata[CTL_HOLD_B];
         fixed_q <= wdata[CTL_FIXED];
         swap_q  <= wdata[CTL_SWAP];
         tval_q  <= wdata[CTL_TVAL_LSB +: TVAL_W];
      end else if (we && addr == RA_TMR) begin
         tmr_en  <= wdata[TMR_EN];
         tpre    <= wdata[TMR_PRE_LSB +: TPRE_W];
      end
   end

   always_comb begin
      ctl.hold  = hold_a | hold_b;
      ctl.fixed = fixed_q;
      ctl.swap  = swap_q;
      ctl.tval  = tval_q;
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         RA_ADDR_LO: rdata = addr_lo_q;
         RA_ADDR_HI: rdata = 32'(addr_hi_q);
         RA_SIZE:    rdata = 32'({cnt_q, 2'b00}) | {31'd0, last_q};
         RA_CTRL: begin
            rdata[CTL_HOLD_A]               = hold_a;
            rdata[CTL_HOLD_B]               = hold_b;
            rdata[CTL_TVAL_LSB +: TVAL_W]   = tval_q;
            rdata[CTL_FIXED]                = fixed_q;
            rdata[CTL_SWAP]                 = swap_q;
         end
         RA_TMR: begin
            rdata[TMR_PRE_LSB +: TPRE_W]    = tpre;
            rdata[TMR_EN]                   = tmr_en;
         end
         RA_SUM:     rdata = sum_q;
         RA_STAT:    rdata = {31'd0, busy_q};
         default:    rdata = '0;
      endcase
   end

   assert_hold_reg_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ctl));
endmodule

// File: rtl/m2s_fetch.sv
module m2s_fetch
   import m2s_pkg::*;
#(
   parameter int HI_W    = 17,
   parameter int CNT_W   = 27,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      wdata,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic             ld_size,
   input  logic             ld_sum,
   input  ctl_t             ctl,
   output logic             mem_req,
   output logic [HI_W+31:0] mem_addr,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_err,
   output logic             st_valid,
   output logic [31:0]      st_data,
   output logic             st_last,
   input  logic             st_ready,
   output logic [31:0]      addr_lo_q,
   output logic [HI_W-1:0]  addr_hi_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             last_q,
   output logic [31:0]      sum_q,
   output logic             busy_q,
   output logic             ev_done,
   output logic             ev_bus_err
);
   localparam int WA_W = 30 + HI_W;

   logic [WA_W-1:0] wa;
   logic            buf_v, buf_fin, buf_last;
   logic [31:0]     buf_data, shaped;
   logic            fetch_go, take, sum_upd;

   generate
      if (SWAP_EN) begin : g_swap
         assign shaped = ctl.swap ? rev_bytes(mem_rdata) : mem_rdata;
      end else begin : g_noswap
         assign shaped = mem_rdata;
      end
   endgenerate

   assign mem_req   = busy_q && !ctl.hold && (cnt_q != '0) && !buf_v;
   assign mem_addr  = {wa, 2'b00};
   assign fetch_go  = mem_req && mem_ack && !ld_size;
   assign st_valid  = buf_v;
   assign st_data   = buf_data;
   assign st_last   = buf_last;
   assign take      = buf_v && st_ready && !ld_size;
   assign addr_lo_q = {wa[29:0], 2'b00};
   assign addr_hi_q = wa[WA_W-1:30];
   assign sum_upd   = fetch_go && !mem_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wa <= '0;
      end else if (ld_lo) begin
         wa[29:0] <= wdata[31:2];
      end else if (ld_hi) begin
         wa[WA_W-1:30] <= wdata[HI_W-1:0];
      end else if (fetch_go && !ctl.fixed) begin
         wa <= wa + WA_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (ld_sum) begin
         sum_q <= wdata;
      end else if (sum_upd) begin
         sum_q <= sum_q + mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         last_q     <= 1'b0;
         busy_q     <= 1'b0;
         buf_v      <= 1'b0;
         buf_fin    <= 1'b0;
         buf_last   <= 1'b0;
         buf_data   <= '0;
         ev_done    <= 1'b0;
         ev_bus_err <= 1'b0;
      end else begin
         ev_done    <= 1'b0;
         ev_bus_err <= fetch_go && mem_err;
         if (ld_size) begin
            cnt_q    <= wdata[CNT_W+1:2];
            last_q   <= wdata[0];
            buf_v    <= 1'b0;
            busy_q   <= (wdata[CNT_W+1:2] != '0);
            ev_done  <= (wdata[CNT_W+1:2] == '0);
         end else if (fetch_go) begin
            buf_v    <= 1'b1;
            buf_data <= shaped;
            buf_fin  <= (cnt_q == CNT_W'(1));
            buf_last <= (cnt_q == CNT_W'(1)) && last_q;
            cnt_q    <= cnt_q - CNT_W'(1);
         end else if (take) begin
            buf_v    <= 1'b0;
            if (buf_fin) begin
               busy_q  <= 1'b0;
               ev_done <= 1'b1;
            end
         end
      end
   end

   assert_sum_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mem_req && mem_ack) && !ld_sum) |=> $stable(sum_q));
   assert_word_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !st_ready && !ld_size) |=> (st_valid && $stable(st_data)));
   assert_fixed_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.fixed && !ld_lo && !ld_hi) |=> $stable(mem_addr));
   assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.hold && !ld_size) |=> $stable(cnt_q));
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |-> (!busy_q && !st_valid));
   assert_last_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_last) |-> (cnt_q == '0));
endmodule

// File: rtl/m2s_timer.sv
module m2s_timer
   import m2s_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stall,
   input  logic [TPRE_W-1:0] pre,
   input  logic [TVAL_W-1:0] tval,
   output logic              ev_timeout
);
   logic [TPRE_W-1:0] pcnt;
   logic [TVAL_W-1:0] tcnt;
   logic              fired;
   logic              run;

   assign run = en && stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt       <= '0;
         tcnt       <= '0;
         fired      <= 1'b0;
         ev_timeout <= 1'b0;
      end else if (!run) begin
         pcnt       <= '0;
         tcnt       <= '0;
         fired      <= 1'b0;
         ev_timeout <= 1'b0;
      end else begin
         ev_timeout <= 1'b0;
         if (!fired) begin
            if (pcnt == pre) begin
               pcnt <= '0;
               if (tval != '0 && tcnt == tval - TVAL_W'(1)) begin
                  fired      <= 1'b1;
                  ev_timeout <= 1'b1;
                  tcnt       <= '0;
               end else begin
                  tcnt <= tcnt + TVAL_W'(1);
               end
            end else begin
               pcnt <= pcnt + TPRE_W'(1);
            end
         end
      end
   end

   assert_timeout_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_timeout |=> !ev_timeout);
   assert_timeout_needs_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ev_timeout);
endmodule

// File: rtl/mem2stream_src.sv
module mem2stream_src
   import m2s_pkg::*;
#(
   parameter int HI_W    = 17,
   parameter int CNT_W   = 27,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             mem_req,
   output logic [HI_W+31:0] mem_addr,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_err,
   output logic             st_valid,
   output logic [31:0]      st_data,
   output logic             st_last,
   input  logic             st_ready,
   output logic             ev_done,
   output logic             ev_mem_done,
   output logic             ev_bus_err,
   output logic             ev_timeout
);
   generate
      if (HI_W < 1 || HI_W > 31) begin : g_bad_hi
         $error("mem2stream_src: HI_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 29) begin : g_bad_cnt
         $error("mem2stream_src: CNT_W out of range");
      end
   endgenerate

   ctl_t              ctl;
   logic              tmr_en;
   logic [TPRE_W-1:0] tpre;
   logic              ld_lo, ld_hi, ld_size, ld_sum;
   logic [31:0]       addr_lo_q, sum_q;
   logic [HI_W-1:0]   addr_hi_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              last_q, busy_q, done_w;

   m2s_regs #(.HI_W(HI_W), .CNT_W(CNT_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .ctl(ctl), .tmr_en(tmr_en), .tpre(tpre),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_size(ld_size), .ld_sum(ld_sum),
      .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q), .cnt_q(cnt_q),
      .last_q(last_q), .sum_q(sum_q), .busy_q(busy_q), .rdata(reg_rdata)
   );

   m2s_fetch #(.HI_W(HI_W), .CNT_W(CNT_W), .SWAP_EN(SWAP_EN)) fetch_i (
      .clk(clk), .rst_n(rst_n), .wdata(reg_wdata),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_size(ld_size), .ld_sum(ld_sum), .ctl(ctl),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err),
      .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
      .addr_lo_q(addr_lo_q), .addr_hi_q(addr_hi_q), .cnt_q(cnt_q), .last_q(last_q),
      .sum_q(sum_q), .busy_q(busy_q), .ev_done(done_w), .ev_bus_err(ev_bus_err)
   );

   m2s_timer timer_i (
      .clk(clk), .rst_n(rst_n), .en(tmr_en), .stall(busy_q && !st_ready),
      .pre(tpre), .tval(ctl.tval), .ev_timeout(ev_timeout)
   );

   assign ev_done     = done_w;
   assign ev_mem_done = done_w;

   assert_size_starts_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == RA_SIZE && reg_wdata[CNT_W+1:2] != '0) |=> busy_q);
endmodule

// File: tb/mem2stream_src_tb_top.sv
module mem2stream_src_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q = CLK_PERIOD / 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_ack = 1'b0, mem_err;
   logic [48:0] mem_addr;
   logic [31:0] mem_rdata;
   logic        st_valid, st_last, st_ready = 1'b0;
   logic [31:0] st_data;
   logic        ev_done, ev_mem_done, ev_bus_err, ev_timeout;

   int n_chk = 0, n_bad = 0;
   int got_n = 0, cnt_done = 0, cnt_mdone = 0, cnt_err = 0, cnt_to = 0, to_at = -1, cyc = 0;
   int phase = 0, rdy_mode = 0, ack_mode = 0;
   logic [31:0] got_data [0:63];
   logic        got_last [0:63];
   logic [48:0] err_addr = '1;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] mw(input logic [48:0] a);
      return (a[31:0] * 32'h9E3779B1) ^ {15'd0, a[48:32]} ^ 32'h1234_5678;
   endfunction
   function automatic logic [31:0] bsw(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   assign mem_rdata = mw(mem_addr);
   assign mem_err   = (mem_addr == err_addr);

   mem2stream_src dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err),
      .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
      .ev_done(ev_done), .ev_mem_done(ev_mem_done), .ev_bus_err(ev_bus_err),
      .ev_timeout(ev_timeout)
   );

   initial forever begin
      @(negedge clk);
      phase++;
      st_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : (phase % 3 != 0);
      mem_ack  = (ack_mode == 0) ? 1'b1 : (phase % 2 == 0);
   end

   initial forever begin
      @(negedge clk);
      #(Q);
      if (st_valid && st_ready) begin
         if (got_n < 64) begin
            got_data[got_n] = st_data;
            got_last[got_n] = st_last;
         end
         got_n++;
      end
      if (ev_done) cnt_done++;
      if (ev_mem_done) cnt_mdone++;
      if (ev_bus_err) cnt_err++;
      if (ev_timeout) begin
         cnt_to++;
         to_at = cyc;
      end
      cyc++;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #(Q);
      d = reg_rdata;
   endtask

   task automatic clear_obs();
      got_n = 0; cnt_done = 0; cnt_mdone = 0; cnt_err = 0; cnt_to = 0; to_at = -1;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 400 && cnt_done == 0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_xfer(input int n, input bit sw, input bit fx, input bit lf,
                           input logic [31:0] blo, input logic [16:0] bhi);
      logic [48:0] base, fin;
      logic [31:0] esum, rd, raw, expw;
      base = {bhi, blo};
      reg_write(3'd3, (32'(sw) << 23) | (32'(fx) << 22));
      reg_write(3'd0, blo);
      reg_write(3'd1, 32'(bhi));
      reg_write(3'd5, 32'd0);
      clear_obs();
      reg_write(3'd2, (32'(n) << 2) | 32'(lf));
      wait_done();
      chk(got_n == n, "R10 word count", 64'(got_n), 64'(n));
      esum = '0;
      for (int k = 0; k < n && k < 64; k++) begin
         raw  = mw(fx ? base : base + 49'(4 * k));
         expw = sw ? bsw(raw) : raw;
         esum = esum + raw;
         chk(got_data[k] == expw, sw ? "R6 swapped word" : "R7 word", 64'(got_data[k]), 64'(expw));
         chk(got_last[k] == (lf && k == n - 1), "R9 last flag", 64'(got_last[k]), 64'(lf && k == n - 1));
      end
      reg_read(3'd5, rd);
      chk(rd == esum, "R5 checksum", 64'(rd), 64'(esum));
      reg_read(3'd6, rd);
      chk(rd == 32'd0, "R10 idle after done", 64'(rd), 64'd0);
      chk(cnt_done == 1 && cnt_mdone == 1, n == 0 ? "R4 zero count done" : "R10 done pulses",
          64'(cnt_done * 16 + cnt_mdone), 64'h11);
      fin = fx ? base : base + 49'(4 * n);
      reg_read(3'd0, rd);
      chk(rd == fin[31:0], "R7 final address low", 64'(rd), 64'(fin[31:0]));
      reg_read(3'd1, rd);
      chk(rd == 32'(fin[48:32]), "R2 final address high", 64'(rd), 64'(fin[48:32]));
      reg_read(3'd2, rd);
      chk(rd == 32'(lf), "R3 count reads remaining plus flag", 64'(rd), 64'(lf));
   endtask

   initial begin
      logic [31:0] rd;
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(3'd3, rd); chk(rd == 32'h003F_F800, "R1 ctrl reset", 64'(rd), 64'h003FF800);
      reg_read(3'd4, rd); chk(rd == 32'h0000_FFF0, "R1 timer reset", 64'(rd), 64'hFFF0);
      reg_read(3'd6, rd); chk(rd == 32'd0, "R1 status reset", 64'(rd), 64'd0);
      reg_read(3'd5, rd); chk(rd == 32'd0, "R1 checksum reset", 64'(rd), 64'd0);
      chk(st_valid == 1'b0, "R1 stream idle", 64'(st_valid), 64'd0);

      // R2 low address bits ignored
      reg_write(3'd0, 32'h0000_2003);
      reg_read(3'd0, rd); chk(rd == 32'h0000_2000, "R2 low bits ignored", 64'(rd), 64'h2000);

      // R4 zero count
      clear_obs();
      reg_write(3'd2, 32'd0);
      repeat (3) @(negedge clk);
      chk(cnt_done == 1, "R4 zero count pulse", 64'(cnt_done), 64'd1);
      reg_read(3'd6, rd); chk(rd == 32'd0, "R4 zero count idle", 64'(rd), 64'd0);

      // sweep: R5 R6 R7 R9 R10 R14
      for (int n = 0; n < 6; n++) begin
         for (int c = 0; c < 8; c++) begin
            rdy_mode = ((n + c) % 2 == 1) ? 2 : 0;
            ack_mode = (c % 2) ^ (n % 2);
            run_xfer(n, c[0], c[1], c[2],
                     (c == 5) ? 32'hFFFF_FFF8 : 32'h0000_1000 + 32'(n * 64), 17'(c));
         end
      end
      rdy_mode = 0; ack_mode = 0;

      // R8 pause bits
      reg_write(3'd3, 32'h1);
      reg_write(3'd0, 32'h0000_4000);
      reg_write(3'd1, 32'd0);
      clear_obs();
      reg_write(3'd2, 32'd13);
      repeat (8) @(negedge clk);
      chk(got_n == 0, "R8 pause A stops", 64'(got_n), 64'd0);
      reg_read(3'd0, rd); chk(rd == 32'h0000_4000, "R8 address held", 64'(rd), 64'h4000);
      reg_read(3'd6, rd); chk(rd == 32'd1, "R3 busy while paused", 64'(rd), 64'd1);
      reg_read(3'd2, rd); chk(rd == 32'd13, "R3 count readback with flag", 64'(rd), 64'd13);
      reg_write(3'd3, 32'h2);
      repeat (6) @(negedge clk);
      chk(got_n == 0, "R8 pause B stops", 64'(got_n), 64'd0);
      reg_write(3'd3, 32'h0);
      wait_done();
      chk(got_n == 3, "R8 resume completes", 64'(got_n), 64'd3);
      chk(got_last[2] == 1'b1 && got_last[0] == 1'b0, "R9 last on final only",
          64'({got_last[0], got_last[2]}), 64'd1);

      // R11 bus error
      err_addr = 49'h0_0000_3004;
      reg_write(3'd0, 32'h0000_3000);
      reg_write(3'd5, 32'd0);
      clear_obs();
      reg_write(3'd2, 32'd12);
      wait_done();
      chk(cnt_err == 1, "R11 error pulse", 64'(cnt_err), 64'd1);
      chk(got_n == 3 && got_data[1] == mw(49'h3004), "R11 error word emitted",
          64'(got_data[1]), 64'(mw(49'h3004)));
      reg_read(3'd5, rd);
      chk(rd == mw(49'h3000) + mw(49'h3008), "R5 error word excluded", 64'(rd),
          64'(mw(49'h3000) + mw(49'h3008)));
      err_addr = '1;

      // R13 restart while busy
      rdy_mode = 1;
      reg_write(3'd0, 32'h0000_5000);
      reg_write(3'd2, 32'd32);
      repeat (5) @(negedge clk);
      #(Q);
      chk(st_valid && st_data == mw(49'h5000), "R14 word held under backpressure",
          64'(st_data), 64'(mw(49'h5000)));
      clear_obs();
      reg_write(3'd2, 32'd8);
      rdy_mode = 0;
      wait_done();
      chk(got_n == 2, "R13 restart count", 64'(got_n), 64'd2);
      chk(got_data[0] == mw(49'h5004) && got_data[1] == mw(49'h5008), "R13 restart data",
          64'(got_data[0]), 64'(mw(49'h5004)));

      // R12 timeout: tval 3, prescale 1 -> 6 stalled cycles
      rdy_mode = 1;
      reg_write(3'd3, 32'd3 << 10);
      reg_write(3'd4, (32'd1 << 22) | (32'd1 << 4));
      clear_obs();
      reg_write(3'd2, 32'd8);
      c0 = cyc;
      repeat (20) @(negedge clk);
      chk(cnt_to == 1, "R12 single timeout pulse", 64'(cnt_to), 64'd1);
      chk(to_at == c0 + 6, "R12 timeout timing", 64'(to_at - c0), 64'd6);
      rdy_mode = 0;
      wait_done();
      reg_write(3'd4, 32'd0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule